// File: doc/BRIEF.md
# Pulse and Acquisition Sequencer

This block times one pulse-echo measurement and repeats it. When a trigger arrives, it first drives the excitation output high for a programmed number of clock cycles. It then drives the damping output high for a second programmed length. After a programmed wait, it opens an acquisition window that tells the sample packer downstream which cycles to keep. The next pass starts at a fixed distance from the start of the previous pass. That distance is the repetition time, or the length of one whole pass if the repetition time is shorter.

A trigger can come from a debounced pushbutton or from the rising edge of an external logic input. A second pushbutton switches between single mode and loop mode:
- In single mode, each trigger gives exactly one pass.
- In loop mode, each trigger gives a programmed number of passes, one after another.

Four LEDs show the active mode, a ready/busy indication and the capture window. All timing values are sampled when a run starts, so the host may rewrite them while a run is in progress.

Top module: `pacq_sequencer`

## Requirements
- R1: After reset, `busy`, `trig_out`, `pulse_on`, `pulse_off` and `acq_window` are low, the mode is single, and `led` reads 4'b0101.
- R2: A run starts on a button press held for at least DEB_CYCLES cycles after synchronisation, or on a rising edge of `ext_trig`. A press shorter than that starts nothing, and each press gives one start.
- R3: Within a pass, with cycle index c counted from 0 at the pass start:
  - `pulse_on` is high for c < Pon.
  - `pulse_off` is high for Pon <= c < Pon+Poff.
  - `acq_window` is high for Pon+Poff+Tdelay <= c < Pon+Poff+Tdelay+Tacq.
  - At most one of the three is high, and a phase of length zero is skipped.
- R4: `acq_window` is high for exactly Tacq cycles in every pass.
- R5: Each pass lasts max(RT, Pon+Poff+Tdelay+Tacq, 1) cycles. The next pass begins on the cycle after the last one.
- R6: A run has one pass in single mode. In loop mode it has N passes, and N = 0 counts as one pass.
- R7: A trigger that arrives while `busy` is high is ignored. It neither restarts nor extends the run.
- R8: A mode press while idle toggles between single and loop mode. A mode press while busy has no effect. `led[0]` is high in single mode and `led[1]` is high in loop mode.
- R9: While idle, `led[2]` is steady high. While busy, it equals bit BLINK_W-1 of the run's cycle count, starting from 0 at the first busy cycle. `led[3]` follows `acq_window`.
- R10: The timing and count inputs are captured in the cycle a run is accepted. Later changes to them do not alter that run.
- R11: `busy` is high for every cycle of a run. `trig_out` is high only in the first cycle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_trig | input | 1 | Raw manual trigger button, active high |
| btn_mode | input | 1 | Raw mode select button, active high |
| ext_trig | input | 1 | External trigger; its rising edge starts a run |
| cfg_pon | input | CNT_W | Excitation pulse length in cycles |
| cfg_poff | input | CNT_W | Damping pulse length in cycles |
| cfg_delay | input | CNT_W | Wait between the end of damping and the acquisition window |
| cfg_acq | input | CNT_W | Acquisition window length in cycles |
| cfg_rep | input | CNT_W+2 | Repetition time, measured from one pass start to the next |
| cfg_count | input | NACQ_W | Number of passes in loop mode |
| busy | output | 1 | High while a run is in progress |
| trig_out | output | 1 | High in the first cycle of a run |
| pulse_on | output | 1 | Excitation pulse |
| pulse_off | output | 1 | Damping pulse |
| acq_window | output | 1 | Acquisition window for the sample packer |
| led | output | 4 | {capture, ready/blink, loop, single} |

## Verification
Some properties are checked by assertions on every cycle:
- The three phase outputs are mutually exclusive.
- The window width matches the captured Tacq at the end of each pass.
- The pass counter steps by one until the repetition boundary and stays below it.
- A trigger during a run leaves the captured pass state untouched.
- The mode never changes while busy.
- The ready LED stays high while idle.
- `trig_out` only appears in cycle zero.

Other behaviour needs the bench's scenarios. These are the exact per-cycle waveform against max(RT, sum), the pass count in each mode with the zero-count case, the rejection of a short button glitch, the immunity to configuration writes during a run, and the blink phase.

// File: rtl/pacq_pkg.sv
package pacq_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_LOOP   = 1'b1
  } pacq_mode_e;

  // Length of one pass: the repetition time, stretched to fit all phases,
  // never shorter than one cycle.
  function automatic logic [31:0] pacq_period(input logic [31:0] p_len,
                                              input logic [31:0] f_len,
                                              input logic [31:0] d_len,
                                              input logic [31:0] a_len,
                                              input logic [31:0] rep);
    logic [31:0] total;
    logic [31:0] span;
    total = p_len + f_len + d_len + a_len;
    span  = (rep > total) ? rep : total;
    if (span == 32'd0) span = 32'd1;
    return span;
  endfunction

  // Number of passes in one run.
  function automatic logic [31:0] pacq_passes(input pacq_mode_e mode,
                                              input logic [31:0] count);
    if (mode == MODE_SINGLE) return 32'd1;
    if (count == 32'd0)      return 32'd1;
    return count;
  endfunction

endpackage

// File: rtl/pacq_debounce.sv
module pacq_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic press_o
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam logic [DW-1:0] DLAST = DW'(DEB_CYCLES - 1);

  logic       sync1_q, sync2_q;
  logic       stable_q;
  logic [DW-1:0] cnt_q;
  logic       press_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q != stable_q) begin
        if (cnt_q == DLAST) begin
          stable_q <= sync2_q;
          cnt_q    <= '0;
          press_q  <= sync2_q;
        end else begin
          cnt_q   <= cnt_q + DW'(1);
          press_q <= 1'b0;
        end
      end else begin
        cnt_q   <= '0;
        press_q <= 1'b0;
      end
    end
  end

  assign press_o = press_q;

  // one start per press: the pulse is never two cycles wide
  assert_single_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/pacq_edge_sync.sv
module pacq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q, rise_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      rise_q <= s2_q & ~s3_q;
    end
  end

  assign rise_o = rise_q;

endmodule

// File: rtl/pacq_timeline.sv
module pacq_timeline
  import pacq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NACQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  pacq_mode_e        mode,
  input  logic [CNT_W-1:0]  cfg_pon,
  input  logic [CNT_W-1:0]  cfg_poff,
  input  logic [CNT_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_acq,
  input  logic [CNT_W+1:0]  cfg_rep,
  input  logic [NACQ_W-1:0] cfg_count,
  output logic              running_o,
  output logic              start_evt_o,
  output logic              trig_o,
  output logic              pulse_on_o,
  output logic              pulse_off_o,
  output logic              acq_o
);
  localparam int SUM_W = CNT_W + 2;

  // captured phase boundaries, measured from the pass start
  logic [SUM_W-1:0]  b_on_q, b_off_q, b_dly_q, b_acq_q, period_q;
  logic [SUM_W-1:0]  cyc_q;
  logic [NACQ_W-1:0] left_q;
  logic              running_q, trig_q;

  // named internal events
  logic start_evt, last_cyc, run_done;
  logic [SUM_W-1:0]  period_d;
  logic [NACQ_W-1:0] passes_d;

  assign start_evt = start_req & ~running_q;
  assign last_cyc  = running_q & (cyc_q == period_q - SUM_W'(1));
  assign run_done  = last_cyc & (left_q == '0);

  always_comb begin
    logic [31:0] per32, pas32;
    per32 = pacq_period(32'(cfg_pon), 32'(cfg_poff), 32'(cfg_delay),
                        32'(cfg_acq), 32'(cfg_rep));
    pas32 = pacq_passes(mode, 32'(cfg_count));
    period_d = per32[SUM_W-1:0];
    passes_d = pas32[NACQ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      trig_q    <= 1'b0;
      cyc_q     <= '0;
      left_q    <= '0;
      period_q  <= SUM_W'(1);
      b_on_q    <= '0;
      b_off_q   <= '0;
      b_dly_q   <= '0;
      b_acq_q   <= '0;
    end else if (start_evt) begin
      running_q <= 1'b1;
      trig_q    <= 1'b1;
      cyc_q     <= '0;
      left_q    <= passes_d - NACQ_W'(1);
      period_q  <= period_d;
      b_on_q    <= SUM_W'(cfg_pon);
      b_off_q   <= SUM_W'(cfg_pon) + SUM_W'(cfg_poff);
      b_dly_q   <= SUM_W'(cfg_pon) + SUM_W'(cfg_poff) + SUM_W'(cfg_delay);
      b_acq_q   <= SUM_W'(cfg_pon) + SUM_W'(cfg_poff) + SUM_W'(cfg_delay)
                   + SUM_W'(cfg_acq);
    end else if (running_q) begin
      trig_q <= 1'b0;
      if (last_cyc) begin
        cyc_q <= '0;
        if (run_done) running_q <= 1'b0;
        else          left_q    <= left_q - NACQ_W'(1);
      end else begin
        cyc_q <= cyc_q + SUM_W'(1);
      end
    end
  end

  assign running_o   = running_q;
  assign start_evt_o = start_evt;
  assign trig_o      = trig_q;
  assign pulse_on_o  = running_q & (cyc_q < b_on_q);
  assign pulse_off_o = running_q & (cyc_q >= b_on_q) & (cyc_q < b_off_q);
  assign acq_o       = running_q & (cyc_q >= b_dly_q) & (cyc_q < b_acq_q);

  // checker-side counter of window cycles inside the current pass
  logic [SUM_W-1:0] acq_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !running_q || last_cyc) acq_seen_q <= '0;
    else if (acq_o)                       acq_seen_q <= acq_seen_q + SUM_W'(1);
  end

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_on_o, pulse_off_o, acq_o}));

  assert_acq_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_cyc |-> (acq_seen_q + SUM_W'(acq_o)) == (b_acq_q - b_dly_q));

  assert_pass_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !last_cyc) |=> (running_q && cyc_q == $past(cyc_q) + SUM_W'(1)));

  assert_pass_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (cyc_q < period_q));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && start_req && !last_cyc) |=>
      (running_q && !trig_q && $stable(left_q) && $stable(period_q)));

  assert_trig_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (running_q && cyc_q == '0));

endmodule

// File: rtl/pacq_led.sv
module pacq_led
  import pacq_pkg::*;
#(
  parameter int BLINK_W = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pacq_mode_e mode,
  input  logic       running,
  input  logic       start_evt,
  input  logic       acq_window,
  output logic [3:0] led
);
  logic [BLINK_W-1:0] blink_q;

  always_ff @(posedge clk) begin
    if (!rst_n || start_evt) blink_q <= '0;
    else if (running)        blink_q <= blink_q + BLINK_W'(1);
  end

  assign led[0] = (mode == MODE_SINGLE);
  assign led[1] = (mode == MODE_LOOP);
  assign led[2] = running ? blink_q[BLINK_W-1] : 1'b1;
  assign led[3] = acq_window;

  assert_led_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> led[2]);

endmodule

// File: rtl/pacq_sequencer.sv
module pacq_sequencer
  import pacq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NACQ_W     = 8,
  parameter int DEB_CYCLES = 65536,
  parameter int BLINK_W    = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_trig,
  input  logic              btn_mode,
  input  logic              ext_trig,
  input  logic [CNT_W-1:0]  cfg_pon,
  input  logic [CNT_W-1:0]  cfg_poff,
  input  logic [CNT_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_acq,
  input  logic [CNT_W+1:0]  cfg_rep,
  input  logic [NACQ_W-1:0] cfg_count,
  output logic              busy,
  output logic              trig_out,
  output logic              pulse_on,
  output logic              pulse_off,
  output logic              acq_window,
  output logic [3:0]        led
);
  logic trig_press, mode_press, ext_rise, start_req, start_evt, running;
  pacq_mode_e mode_q;

  pacq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_trig (
    .clk(clk), .rst_n(rst_n), .raw_i(btn_trig), .press_o(trig_press));

  pacq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_mode (
    .clk(clk), .rst_n(rst_n), .raw_i(btn_mode), .press_o(mode_press));

  pacq_edge_sync u_ext (
    .clk(clk), .rst_n(rst_n), .async_i(ext_trig), .rise_o(ext_rise));

  assign start_req = trig_press | ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n)                      mode_q <= MODE_SINGLE;
    else if (mode_press && !running) mode_q <= (mode_q == MODE_SINGLE) ? MODE_LOOP
                                                                       : MODE_SINGLE;
  end

  pacq_timeline #(.CNT_W(CNT_W), .NACQ_W(NACQ_W)) u_timeline (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode(mode_q),
    .cfg_pon(cfg_pon), .cfg_poff(cfg_poff), .cfg_delay(cfg_delay),
    .cfg_acq(cfg_acq), .cfg_rep(cfg_rep), .cfg_count(cfg_count),
    .running_o(running), .start_evt_o(start_evt), .trig_o(trig_out),
    .pulse_on_o(pulse_on), .pulse_off_o(pulse_off), .acq_o(acq_window));

  pacq_led #(.BLINK_W(BLINK_W)) u_led (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .running(running),
    .start_evt(start_evt), .acq_window(acq_window), .led(led));

  assign busy = running;

  assert_mode_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(mode_q));

endmodule

// File: tb/pacq_sequencer_tb_top.sv
module pacq_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NACQ_W     = 4;
  localparam int DEB        = 4;
  localparam int BW         = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_trig = 1'b0, btn_mode = 1'b0, ext_trig = 1'b0;
  logic [CNT_W-1:0]  cfg_pon = '0, cfg_poff = '0, cfg_delay = '0, cfg_acq = '0;
  logic [CNT_W+1:0]  cfg_rep = '0;
  logic [NACQ_W-1:0] cfg_count = '0;
  logic busy, trig_out, pulse_on, pulse_off, acq_window;
  logic [3:0] led;

  int errors = 0;
  int checks = 0;
  bit armed  = 1'b0;
  logic [6:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pacq_sequencer #(.CNT_W(CNT_W), .NACQ_W(NACQ_W), .DEB_CYCLES(DEB), .BLINK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_trig(btn_trig), .btn_mode(btn_mode),
    .ext_trig(ext_trig), .cfg_pon(cfg_pon), .cfg_poff(cfg_poff),
    .cfg_delay(cfg_delay), .cfg_acq(cfg_acq), .cfg_rep(cfg_rep),
    .cfg_count(cfg_count), .busy(busy), .trig_out(trig_out),
    .pulse_on(pulse_on), .pulse_off(pulse_off), .acq_window(acq_window),
    .led(led));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver side: compute the expected per-cycle trace of one run
  // vector = {trig_out, busy, pulse_on, pulse_off, acq_window, led[2], led[3]}
  task automatic expect_run(input int p, input int f, input int d, input int a,
                            input int rt, input int n, input bit loop_mode);
    int sum, per, passes, k;
    sum = p + f + d + a;
    per = (rt > sum) ? rt : sum;
    if (per == 0) per = 1;
    passes = (!loop_mode || n == 0) ? 1 : n;
    k = 0;
    for (int ps = 0; ps < passes; ps++) begin
      for (int c = 0; c < per; c++) begin
        exp_q.push_back({(ps == 0 && c == 0), 1'b1, (c < p),
                         (c >= p && c < p + f), (c >= p + f + d && c < sum),
                         1'((k >> (BW - 1)) & 1), (c >= p + f + d && c < sum)});
        k++;
      end
    end
    exp_q.push_back(7'b0000010);
  endtask

  // monitor side: aligns on the first busy cycle and compares every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!armed && exp_q.size() > 0 && busy) armed = 1'b1;
      if (armed) begin
        logic [6:0] got, want;
        got  = {trig_out, busy, pulse_on, pulse_off, acq_window, led[2], led[3]};
        want = exp_q.pop_front();
        chk(got == want, "R3/R4/R5/R6/R9/R11 trace", int'(got), int'(want));
        if (exp_q.size() == 0) armed = 1'b0;
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || armed) && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, "R6 run completed", exp_q.size(), 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic set_cfg(input int p, input int f, input int d, input int a,
                         input int rt, input int n);
    cfg_pon = CNT_W'(p); cfg_poff = CNT_W'(f); cfg_delay = CNT_W'(d);
    cfg_acq = CNT_W'(a); cfg_rep = (CNT_W+2)'(rt); cfg_count = NACQ_W'(n);
  endtask

  task automatic pulse_ext();
    @(posedge clk); #1 ext_trig = 1'b1;
    repeat (2) @(posedge clk); #1 ext_trig = 1'b0;
  endtask

  task automatic press(ref logic b, input int hold);
    @(posedge clk); #1 b = 1'b1;
    repeat (hold) @(posedge clk); #1 b = 1'b0;
    repeat (DEB + 4) @(posedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk({busy, trig_out, pulse_on, pulse_off, acq_window} == 5'b0, "R1 outputs idle",
        {busy, trig_out, pulse_on, pulse_off, acq_window}, 0);
    chk(led == 4'b0101, "R1 led", led, 4'b0101);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2/R6: external edge, single mode, RT shorter than the phases, N ignored
    set_cfg(2, 3, 1, 4, 5, 3);
    expect_run(2, 3, 1, 4, 5, 3, 1'b0);
    pulse_ext();
    drain();

    // R2: a short glitch on the trigger button starts nothing
    press(btn_trig, 2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R2 glitch ignored", busy, 0);
    end

    // R8: mode press while idle enters loop mode
    press(btn_mode, DEB + 4);
    @(negedge clk);
    chk(led[1:0] == 2'b10, "R8 loop mode led", led[1:0], 2'b10);

    // R5/R6/R7/R8/R10: button trigger, loop of 3, RT longer than the phases
    set_cfg(1, 1, 2, 3, 12, 3);
    expect_run(1, 1, 2, 3, 12, 3, 1'b1);
    press(btn_trig, DEB + 4);
    wait (busy == 1'b1);
    repeat (3) @(posedge clk);
    #1 set_cfg(5, 5, 5, 5, 40, 1);        // R10: written mid-run, must not apply
    pulse_ext();                           // R7: trigger while busy
    press(btn_mode, DEB + 4);              // R8: mode press while busy
    drain();
    @(negedge clk);
    chk(led[1:0] == 2'b10, "R8 mode unchanged by busy press", led[1:0], 2'b10);
    chk(busy == 1'b0, "R7 no restart after run", busy, 0);

    // R3/R6: zero-length phases skipped, N = 0 gives one pass
    set_cfg(0, 2, 0, 1, 0, 0);
    expect_run(0, 2, 0, 1, 0, 0, 1'b1);
    pulse_ext();
    drain();

    // R4/R5: window runs right to the pass end, loop of 2 back to back
    set_cfg(0, 0, 0, 3, 2, 2);
    expect_run(0, 0, 0, 3, 2, 2, 1'b1);
    pulse_ext();
    drain();

    // R8: back to single mode
    press(btn_mode, DEB + 4);
    @(negedge clk);
    chk(led == 4'b0101, "R8 single mode led", led, 4'b0101);

    // R6: single mode with long blink, all phases present
    set_cfg(3, 2, 2, 5, 20, 7);
    expect_run(3, 2, 2, 5, 20, 7, 1'b0);
    press(btn_trig, DEB + 2);
    drain();

    report();
  end

endmodule